// File: doc/BRIEF.md
# Ping-Pong Burst Write Queue

This block gives a processor two 32-byte staging buffers that it fills word by word and then sends to memory as one eight-beat burst on command. Stores carry a small word address whose top bit picks a buffer and whose lower bits pick the word inside it. A separate kick command names a buffer and the upper bits of a 32-byte aligned target address. The queue then sends that buffer's eight words, lowest word first, through a valid/ready write master. While one buffer drains, the processor can keep filling the other, so large copies can run back to back.

Each buffer has its own state machine. `SLOT_FILL` accepts stores. The transition *kick* moves it to `SLOT_QUEUED`. The transition *grant* (the master picks it) moves it to `SLOT_DRAIN`. The transition *final beat accepted* returns it to `SLOT_FILL`. The master has two states. `MST_IDLE` moves to `MST_BURST` on *start*, when some buffer is queued. `MST_BURST` takes *advance* on every beat that is accepted before the last one and *hold* while the beat is refused. It returns to `MST_IDLE` on *finish*, when the eighth beat is accepted. A buffer is busy in every state other than `SLOT_FILL`. Stores and kicks aimed at a busy buffer are held off by a low ready signal.

Top module: `sq_burst_top`

## Requirements
- R1: After reset both busy bits are 0, `m_valid` is 0, both ready outputs are 1, and every word of both buffers reads as zero.
- R2: A store is accepted when `st_valid` and `st_ready` are both high at a clock edge. `st_waddr[3]` picks the buffer (0 is buffer 0, 1 is buffer 1), and `st_waddr[2:0]` picks the word, which is beat number `st_waddr[2:0]` of that buffer's burst.
- R3: An accepted kick sets `busy[kick_sel]` in the next cycle. The burst for that buffer targets byte address `{kick_base, 5'b00000}`.
- R4: A burst has exactly eight beats. Beat n carries word n of the buffer at address base + 4·n, and `m_last` is high on beat 7 and on no other beat.
- R5: While `m_valid` is high and `m_ready` is low, `m_addr`, `m_data` and `m_last` hold their values and `m_valid` stays high.
- R6: While a buffer is busy, `st_ready` is low for stores addressed to it and `kick_ready` is low for kicks naming it. An offered store that is withdrawn before that buffer goes idle leaves its contents unchanged.
- R7: Stores to the idle buffer are accepted while the other buffer drains.
- R8: The cycle after the final beat is accepted, the drained buffer's busy bit is 0 and `m_valid` is 0.
- R9: A store and a kick to the same idle buffer in the same cycle are both accepted, and the stored word is part of that burst.
- R10: When kicks come in for both buffers, the bursts go out in kick order.
- R11: With the master idle, a kick accepted at edge k gives `m_valid` high with the first beat after edge k+1.
- R12: Draining does not clear a buffer. Kicking it again without new stores sends the same eight words again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted when high with st_valid |
| st_waddr | input | 4 | Bit 3 picks the buffer, bits 2:0 pick the word |
| st_data | input | 32 | Store data |
| kick_valid | input | 1 | Burst start request |
| kick_ready | output | 1 | Kick accepted when high with kick_valid |
| kick_sel | input | 1 | Buffer to send |
| kick_base | input | 27 | Target address bits 31:5 |
| m_valid | output | 1 | Write beat valid |
| m_ready | input | 1 | Memory accepts the beat |
| m_addr | output | 32 | Byte address of the beat |
| m_data | output | 32 | Beat data |
| m_last | output | 1 | High on the eighth beat |
| busy | output | 2 | Per-buffer busy flags |

## Verification
Two functions can land in the same clock edge. The first pair is a store and a kick to the same idle buffer. The bench drives both in one cycle, then checks that the stored word shows up at its beat of the burst that follows. The second pair is a store to the free buffer in the same cycle that the other buffer's beats are being held off or accepted. The bench stalls the memory side while it fills the second buffer, then compares both bursts, in kick order, against a model of what was stored.

// File: rtl/sq_pkg.sv
package sq_pkg;

    typedef enum logic [1:0] {
        SLOT_FILL   = 2'd0,
        SLOT_QUEUED = 2'd1,
        SLOT_DRAIN  = 2'd2
    } slot_state_t;

    typedef enum logic {
        MST_IDLE  = 1'b0,
        MST_BURST = 1'b1
    } mst_state_t;

    localparam int NUM_SLOTS = 2;

endpackage

// File: rtl/sq_slot.sv
module sq_slot
    import sq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WORDS  = 8,
    parameter int IDX_W  = 3,
    parameter int BASE_W = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              kick_en,
    input  logic [BASE_W-1:0] kick_base,
    input  logic              grant,
    input  logic              done,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [BASE_W-1:0] base,
    output logic              busy,
    output logic              queued
);

    slot_state_t state_q, state_d;
    logic [DATA_W-1:0] mem_q [WORDS];
    logic [BASE_W-1:0] base_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: kick, grant, final beat accepted
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FILL:   if (kick_en) state_d = SLOT_QUEUED;
            SLOT_QUEUED: if (grant)   state_d = SLOT_DRAIN;
            SLOT_DRAIN:  if (done)    state_d = SLOT_FILL;
            default:                  state_d = SLOT_FILL;
        endcase
    end

    // outputs
    always_comb begin
        busy    = (state_q != SLOT_FILL);
        queued  = (state_q == SLOT_QUEUED);
        rd_data = mem_q[rd_idx];
        base    = base_q;
    end

    // word storage and target base
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= '0;
            end
            base_q <= '0;
        end else begin
            if (wr_en) begin
                mem_q[wr_idx] <= wr_data;
            end
            if (kick_en) begin
                base_q <= kick_base;
            end
        end
    end

endmodule

// File: rtl/sq_master.sv
module sq_master
    import sq_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int IDX_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] queued,
    input  logic                 m_ready,
    output logic [NUM_SLOTS-1:0] grant,
    output logic [NUM_SLOTS-1:0] done,
    output logic                 sel,
    output logic [IDX_W-1:0]     beat,
    output logic                 m_valid,
    output logic                 m_last
);

    localparam logic [IDX_W-1:0] LAST_BEAT = IDX_W'(WORDS - 1);

    mst_state_t       state_q, state_d;
    logic             sel_q, sel_d;
    logic [IDX_W-1:0] beat_q, beat_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MST_IDLE;
            sel_q   <= 1'b0;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
            beat_q  <= beat_d;
        end
    end

    // transitions: start, advance, hold, finish
    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        beat_d  = beat_q;
        unique case (state_q)
            MST_IDLE: begin
                if (|queued) begin
                    state_d = MST_BURST;
                    sel_d   = queued[0] ? 1'b0 : 1'b1;
                    beat_d  = '0;
                end
            end
            MST_BURST: begin
                if (m_ready) begin
                    if (beat_q == LAST_BEAT) begin
                        state_d = MST_IDLE;
                    end else begin
                        beat_d = beat_q + 1'b1;
                    end
                end
            end
            default: state_d = MST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        grant   = '0;
        done    = '0;
        m_valid = 1'b0;
        m_last  = 1'b0;
        unique case (state_q)
            MST_IDLE: begin
                if (|queued) grant[sel_d] = 1'b1;
            end
            MST_BURST: begin
                m_valid = 1'b1;
                m_last  = (beat_q == LAST_BEAT);
                if (m_ready && beat_q == LAST_BEAT) done[sel_q] = 1'b1;
            end
            default: ;
        endcase
        sel  = sel_q;
        beat = beat_q;
    end

endmodule

// File: rtl/sq_burst_top.sv
module sq_burst_top
    import sq_pkg::*;
#(
    parameter  int DATA_W  = 32,
    parameter  int WORDS   = 8,
    parameter  int ADDR_W  = 32,
    localparam int BYTES_W = $clog2(DATA_W / 8),
    localparam int IDX_W   = $clog2(WORDS),
    localparam int BLK_W   = IDX_W + BYTES_W,
    localparam int BASE_W  = ADDR_W - BLK_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 st_valid,
    output logic                 st_ready,
    input  logic [IDX_W:0]       st_waddr,
    input  logic [DATA_W-1:0]    st_data,
    input  logic                 kick_valid,
    output logic                 kick_ready,
    input  logic                 kick_sel,
    input  logic [BASE_W-1:0]    kick_base,
    output logic                 m_valid,
    input  logic                 m_ready,
    output logic [ADDR_W-1:0]    m_addr,
    output logic [DATA_W-1:0]    m_data,
    output logic                 m_last,
    output logic [NUM_SLOTS-1:0] busy
);

    logic [NUM_SLOTS-1:0] queued_v;
    logic [NUM_SLOTS-1:0] grant_v;
    logic [NUM_SLOTS-1:0] done_v;
    logic [DATA_W-1:0]    rd_v   [NUM_SLOTS];
    logic [BASE_W-1:0]    base_v [NUM_SLOTS];
    logic                 cur_sel;
    logic [IDX_W-1:0]     cur_beat;
    logic                 st_fire;
    logic                 kick_fire;

    assign st_ready   = !busy[st_waddr[IDX_W]];
    assign kick_ready = !busy[kick_sel];
    assign st_fire    = st_valid && st_ready;
    assign kick_fire  = kick_valid && kick_ready;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        sq_slot #(
            .DATA_W (DATA_W),
            .WORDS  (WORDS),
            .IDX_W  (IDX_W),
            .BASE_W (BASE_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (st_fire && (st_waddr[IDX_W] == 1'(g))),
            .wr_idx    (st_waddr[IDX_W-1:0]),
            .wr_data   (st_data),
            .kick_en   (kick_fire && (kick_sel == 1'(g))),
            .kick_base (kick_base),
            .grant     (grant_v[g]),
            .done      (done_v[g]),
            .rd_idx    (cur_beat),
            .rd_data   (rd_v[g]),
            .base      (base_v[g]),
            .busy      (busy[g]),
            .queued    (queued_v[g])
        );
    end

    sq_master #(
        .WORDS (WORDS),
        .IDX_W (IDX_W)
    ) u_master (
        .clk     (clk),
        .rst_n   (rst_n),
        .queued  (queued_v),
        .m_ready (m_ready),
        .grant   (grant_v),
        .done    (done_v),
        .sel     (cur_sel),
        .beat    (cur_beat),
        .m_valid (m_valid),
        .m_last  (m_last)
    );

    assign m_data = rd_v[cur_sel];
    assign m_addr = {base_v[cur_sel], cur_beat, {BYTES_W{1'b0}}};

endmodule

// File: rtl/sq_burst_chk.sv
module sq_burst_chk #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 8,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              kick_valid,
    input logic              kick_ready,
    input logic              kick_sel,
    input logic              m_valid,
    input logic              m_ready,
    input logic [ADDR_W-1:0] m_addr,
    input logic [DATA_W-1:0] m_data,
    input logic              m_last,
    input logic [1:0]        busy
);

    localparam int IDX_W = $clog2(WORDS);
    localparam int BLK_W = IDX_W + $clog2(DATA_W / 8);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

    logic [IDX_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (m_valid && m_ready) begin
            cnt_q <= m_last ? '0 : cnt_q + 1'b1;
        end
    end

    // R4: last flag only on the eighth beat
    p_last_eighth_r4: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (m_last == (cnt_q == IDX_W'(WORDS - 1))));

    // R4: beats step upward by one word
    p_ascend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && !m_last) |=> (m_valid && (m_addr == $past(m_addr) + STEP)));

    // R3: first beat lands on an aligned block
    p_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && cnt_q == '0) |-> (m_addr[BLK_W-1:0] == '0));

    // R3: accepted kick marks the buffer busy
    p_busy_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_valid && kick_ready) |=> busy[$past(kick_sel)]);

    // R5: refused beat holds still
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_data) && $stable(m_last)));

    // R8: idle cycle after the final beat
    p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && m_last) |=> !m_valid);

    // R3: bursts only while some buffer is busy
    p_valid_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> ($countones(busy) != 0));

endmodule

bind sq_burst_top sq_burst_chk #(
    .DATA_W (DATA_W),
    .WORDS  (WORDS),
    .ADDR_W (ADDR_W)
) u_chk (.*);

// File: tb/sim_sq_burst_top.sv
module sim_sq_burst_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0;
    logic        st_ready;
    logic [3:0]  st_waddr = '0;
    logic [31:0] st_data = '0;
    logic        kick_valid = 1'b0;
    logic        kick_ready;
    logic        kick_sel = 1'b0;
    logic [26:0] kick_base = '0;
    logic        m_valid;
    logic        m_ready = 1'b0;
    logic [31:0] m_addr;
    logic [31:0] m_data;
    logic        m_last;
    logic [1:0]  busy;

    sq_burst_top u0 (.*);

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] rdy_pat = 8'hFF;
    logic [31:0] model [2][8];

    logic [31:0] cap_a [256];
    logic [31:0] cap_d [256];
    logic        cap_l [256];
    int          cap_n = 0;

    // fields: sel | base | seed | ready pattern
    localparam logic [67:0] VEC [6] = '{
        {1'b0, 27'h0000001, 32'h1000_0000, 8'hFF},
        {1'b1, 27'h0ABCDEF, 32'h2222_0001, 8'b1011_0010},
        {1'b0, 27'h7FFFFFF, 32'hFFFF_FFF8, 8'b0101_0101},
        {1'b1, 27'h0000000, 32'h0BAD_F00D, 8'b1110_0001},
        {1'b0, 27'h5555555, 32'hC0DE_0000, 8'b1000_0000},
        {1'b1, 27'h2AAAAAA, 32'h7777_1234, 8'hFF}
    };

    initial begin : rdy_drv
        int k;
        k = 0;
        forever begin
            @(posedge clk);
            #2;
            m_ready = rdy_pat[k % 8];
            k++;
        end
    end

    always @(negedge clk) begin
        if (rst_n && m_valid && m_ready) begin
            cap_a[cap_n % 256] <= m_addr;
            cap_d[cap_n % 256] <= m_data;
            cap_l[cap_n % 256] <= m_last;
            cap_n <= cap_n + 1;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail + 1);
        $finish;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_store(input logic b, input int idx, input logic [31:0] d);
        int g;
        @(posedge clk);
        #2;
        st_valid = 1'b1;
        st_waddr = {b, idx[2:0]};
        st_data  = d;
        g = 0;
        @(negedge clk);
        while (!st_ready && g < 2000) begin
            @(negedge clk);
            g++;
        end
        @(posedge clk);
        #2;
        st_valid = 1'b0;
        model[b][idx] = d;
    endtask

    task automatic do_kick(input logic b, input logic [26:0] base);
        int g;
        @(posedge clk);
        #2;
        kick_valid = 1'b1;
        kick_sel   = b;
        kick_base  = base;
        g = 0;
        @(negedge clk);
        while (!kick_ready && g < 2000) begin
            @(negedge clk);
            g++;
        end
        @(posedge clk);
        #2;
        kick_valid = 1'b0;
    endtask

    task automatic wait_cap(input int target, input string tag);
        int g;
        g = 0;
        while (cap_n < target && g < 5000) begin
            @(negedge clk);
            g++;
        end
        chk({tag, " beats arrived"}, 64'(cap_n >= target), 64'd1);
    endtask

    task automatic expect_burst(input int at, input logic b, input logic [26:0] base, input string tag);
        for (int i = 0; i < 8; i++) begin
            chk({tag, " addr"}, 64'(cap_a[(at + i) % 256]), 64'({base, i[2:0], 2'b00}));
            chk({tag, " data"}, 64'(cap_d[(at + i) % 256]), 64'(model[b][i]));
            chk({tag, " last"}, 64'(cap_l[(at + i) % 256]), 64'(i == 7));
        end
    endtask

    initial begin : main
        int at;
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 8; i++)
                model[b][i] = '0;

        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 m_valid", 64'(m_valid), 64'd0);
        chk("R1 st_ready", 64'(st_ready), 64'd1);
        chk("R1 kick_ready", 64'(kick_ready), 64'd1);

        // R11 / R8 timing with an untouched buffer (R1 zero contents)
        rdy_pat = 8'hFF;
        at = cap_n;
        do_kick(1'b1, 27'h0123456);
        @(negedge clk);
        chk("R3 busy after kick", 64'(busy), 64'b10);
        chk("R11 no beat yet", 64'(m_valid), 64'd0);
        @(negedge clk);
        chk("R11 first beat valid", 64'(m_valid), 64'd1);
        chk("R11 first beat addr", 64'(m_addr), 64'({27'h0123456, 5'b0}));
        repeat (7) @(negedge clk);
        chk("R8 last beat showing", 64'({m_last, busy[1]}), 64'b11);
        @(negedge clk);
        chk("R8 busy cleared", 64'(busy), 64'd0);
        chk("R8 valid dropped", 64'(m_valid), 64'd0);
        wait_cap(at + 8, "R1");
        expect_burst(at, 1'b1, 27'h0123456, "R1 zero contents");

        // vector table: R2 R3 R4 R5
        for (int v = 0; v < 6; v++) begin
            logic        vs;
            logic [26:0] vb;
            logic [31:0] vd;
            vs = VEC[v][67];
            vb = VEC[v][66:40];
            vd = VEC[v][39:8];
            rdy_pat = VEC[v][7:0];
            at = cap_n;
            for (int i = 0; i < 8; i++) begin
                int w;
                w = (v % 2 == 1) ? 7 - i : i;
                do_store(vs, w, vd + 32'(w) * 32'h0101_0101);
            end
            do_kick(vs, vb);
            wait_cap(at + 8, "R4");
            expect_burst(at, vs, vb, "R2 R4 R5 vector");
        end

        // R6 / R7: stall the memory side and work on the other buffer
        rdy_pat = 8'h00;
        for (int i = 0; i < 8; i++) do_store(1'b0, i, 32'hA000_0000 + 32'(i));
        at = cap_n;
        do_kick(1'b0, 27'h0000040);
        @(posedge clk);
        #2;
        st_valid   = 1'b1;
        st_waddr   = 4'b0010;
        st_data    = 32'hDEAD_BEEF;
        kick_valid = 1'b1;
        kick_sel   = 1'b0;
        kick_base  = 27'h0000999;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R6 store stalled", 64'(st_ready), 64'd0);
            chk("R6 kick stalled", 64'(kick_ready), 64'd0);
        end
        @(posedge clk);
        #2;
        st_valid   = 1'b0;
        kick_valid = 1'b0;
        for (int i = 0; i < 8; i++) do_store(1'b1, i, 32'hB000_0000 + 32'(i) * 3);
        chk("R7 fill while other stalled", 64'(busy), 64'b01);
        do_kick(1'b1, 27'h0000080);
        @(negedge clk);
        chk("R3 both busy", 64'(busy), 64'b11);
        rdy_pat = 8'b1101_1011;
        wait_cap(at + 16, "R7");
        expect_burst(at, 1'b0, 27'h0000040, "R6 untouched by stalled store");
        expect_burst(at + 8, 1'b1, 27'h0000080, "R7 second buffer");

        // R9: store and kick in the same cycle
        rdy_pat = 8'hFF;
        at = cap_n;
        @(posedge clk);
        #2;
        st_valid   = 1'b1;
        st_waddr   = 4'b0101;
        st_data    = 32'h5A5A_0F0F;
        kick_valid = 1'b1;
        kick_sel   = 1'b0;
        kick_base  = 27'h0001000;
        @(negedge clk);
        chk("R9 both ready", 64'({st_ready, kick_ready}), 64'b11);
        @(posedge clk);
        #2;
        st_valid   = 1'b0;
        kick_valid = 1'b0;
        model[0][5] = 32'h5A5A_0F0F;
        wait_cap(at + 8, "R9");
        expect_burst(at, 1'b0, 27'h0001000, "R9 same-cycle word");

        // R12: re-kick with no stores
        at = cap_n;
        do_kick(1'b0, 27'h0002000);
        wait_cap(at + 8, "R12");
        expect_burst(at, 1'b0, 27'h0002000, "R12 resend");

        // R10: kick buffer 1 then buffer 0
        rdy_pat = 8'b0110_1110;
        at = cap_n;
        do_kick(1'b1, 27'h0003000);
        do_kick(1'b0, 27'h0004000);
        wait_cap(at + 16, "R10");
        expect_burst(at, 1'b1, 27'h0003000, "R10 first kicked");
        expect_burst(at + 8, 1'b0, 27'h0004000, "R10 second kicked");

        repeat (4) @(negedge clk);
        chk("R8 all idle at end", 64'(busy), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule